// File: doc/BRIEF.md
# Eight-Function Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a simple processor datapath. It takes two operand words and a three-bit function code. It returns one result word and a flag that is high when the result is all zeros. The bench drives it with a clock and a reset, but the block itself holds no state.

The function code is split into two parts. Bit 2 chooses whether the second operand is used as is or bit-inverted. When it is inverted, the adder also gets a carry-in of one, so that addition becomes two's-complement subtraction. Bits 1:0 choose the output:

| Bits 1:0 | Output selected |
|---|---|
| 00 | bitwise AND |
| 01 | bitwise OR |
| 10 | adder sum |
| 11 | signed less-than |

A single adder and a single inversion path therefore serve all seven useful codes. Code 011 is reserved and yields zero. A branch-on-equal unit uses the subtract code and reads the zero flag.

The operand width is a parameter. A second parameter chooses between an inferred adder and an explicit ripple-carry chain.

Top module: `eightfn_alu`

## Requirements
- R1: Function code 3'b000 drives result_o with the bitwise AND of a_i and b_i.
- R2: Function code 3'b001 drives result_o with the bitwise OR of a_i and b_i.
- R3: Function code 3'b010 drives result_o with a_i plus b_i, modulo 2^WIDTH; any carry out of the top bit is discarded.
- R4: Function code 3'b011 is reserved and drives result_o with all zeros, whatever the operands are.
- R5: Function code 3'b100 drives result_o with a_i AND the bitwise inverse of b_i.
- R6: Function code 3'b101 drives result_o with a_i OR the bitwise inverse of b_i.
- R7: Function code 3'b110 drives result_o with a_i minus b_i, modulo 2^WIDTH.
- R8: Function code 3'b111 compares a_i and b_i as two's-complement signed values. Bit 0 of result_o is 1 when a_i is less than b_i and 0 otherwise. All upper bits are 0. The answer stays correct when the subtraction overflows.
- R9: zero_o is high exactly when every bit of result_o is 0. This holds for every function code, including 011.
- R10: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before, and the outputs follow an input change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (inverted when fn_i[2] is 1) |
| fn_i | input | 3 | Function code: bit 2 inverts the second operand; bits 1:0 choose AND, OR, sum or less-than |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block has no memory, so an internal fault shows at the ports as soon as the operands and code are applied, and never later. Three kinds of fault are targeted:
- A wrong carry-in or inversion path shows as an off-by-one difference or a wrong bitwise pattern on the codes with bit 2 set.
- A wrong overflow correction in the compare shows only when the operands have opposite signs and their difference overflows, such as the most negative value against a positive one. Those pairs are applied on purpose.
- A stale or mis-decoded select shows as a wrong word on the reserved code, or as a zero flag that disagrees with the result.

// File: rtl/eightfn_alu_pkg.sv
package eightfn_alu_pkg;

  // Position of the operand-inversion bit inside the function code.
  localparam int unsigned FN_INV_BIT = 2;
  localparam int unsigned FN_W       = 3;

  // Output selection carried in the low two bits of the function code.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  // Adder construction styles.
  localparam int unsigned ADD_INFERRED = 0;
  localparam int unsigned ADD_RIPPLE   = 1;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);

  // Inverting the operand and injecting a carry turns addition into subtraction.
  always_comb begin
    b_eff_o = inv_i ? ~b_i : b_i;
    cin_o   = inv_i;
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned STYLE = 0
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  generate
    if (STYLE == eightfn_alu_pkg::ADD_RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]   = x_i[i] ^ y_i[i] ^ carry[i];
        assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
      end
      // Signed overflow: carry into the top bit differs from carry out of it.
      assign ovf_o = carry[WIDTH] ^ carry[MSB];
    end else begin : g_inferred
      always_comb begin
        sum_o = x_i + y_i + {{(WIDTH-1){1'b0}}, cin_i};
        // Signed overflow: like-signed inputs give an opposite-signed sum.
        ovf_o = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
      end
    end
  endgenerate

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);

  always_comb begin
    and_o = x_i & y_i;
    or_o  = x_i | y_i;
  end

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel #(
  parameter int unsigned WIDTH = 32
) (
  input  eightfn_alu_pkg::alu_sel_e sel_i,
  input  logic                      inv_i,
  input  logic [WIDTH-1:0]          and_i,
  input  logic [WIDTH-1:0]          or_i,
  input  logic [WIDTH-1:0]          sum_i,
  input  logic                      ovf_i,
  output logic [WIDTH-1:0]          result_o,
  output logic                      zero_o
);

  import eightfn_alu_pkg::*;

  localparam int unsigned MSB = WIDTH - 1;

  logic less;

  always_comb begin
    // The sign of the difference is wrong exactly when it overflowed.
    less = sum_i[MSB] ^ ovf_i;
    unique case (sel_i)
      SEL_AND:  result_o = and_i;
      SEL_OR:   result_o = or_i;
      SEL_SUM:  result_o = sum_i;
      SEL_LESS: result_o = inv_i ? {{(WIDTH-1){1'b0}}, less} : '0;
      default:  result_o = '0;
    endcase
    zero_o = ~|result_o;
  end

endmodule

// File: rtl/eightfn_alu.sv
module eightfn_alu #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned ADD_STYLE = eightfn_alu_pkg::ADD_INFERRED
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       fn_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);

  import eightfn_alu_pkg::*;

  logic             inv;
  alu_sel_e         sel;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             ovf;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;

  assign inv = fn_i[FN_INV_BIT];
  assign sel = alu_sel_e'(fn_i[1:0]);

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_i     (b_i),
    .inv_i   (inv),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  alu_adder #(.WIDTH(WIDTH), .STYLE(ADD_STYLE)) u_add (
    .x_i   (a_i),
    .y_i   (b_eff),
    .cin_i (cin),
    .sum_o (sum),
    .ovf_o (ovf)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .x_i   (a_i),
    .y_i   (b_eff),
    .and_o (and_v),
    .or_o  (or_v)
  );

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .sel_i    (sel),
    .inv_i    (inv),
    .and_i    (and_v),
    .or_i     (or_v),
    .sum_i    (sum),
    .ovf_i    (ovf),
    .result_o (result_o),
    .zero_o   (zero_o)
  );

endmodule

// File: rtl/eightfn_alu_chk.sv
module eightfn_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       fn_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);

  always_comb begin
    if (fn_i == 3'b000) begin
      p_and_subset_r1: assert (((result_o & ~a_i) | (result_o & ~b_i)) == '0);
    end
    if (fn_i == 3'b001) begin
      p_or_superset_r2: assert (((result_o & a_i) == a_i) && ((result_o & b_i) == b_i));
    end
    if (fn_i == 3'b010) begin
      p_sum_inverse_r3: assert ((result_o - b_i) == a_i);
    end
    if (fn_i == 3'b011) begin
      p_reserved_zero_r4: assert (result_o == '0);
    end
    if (fn_i == 3'b100) begin
      p_andn_disjoint_r5: assert (((result_o & b_i) == '0) && ((result_o & ~a_i) == '0));
    end
    if (fn_i == 3'b101) begin
      p_orn_cover_r6: assert (((result_o | b_i) == '1) && ((result_o & a_i) == a_i));
    end
    if (fn_i == 3'b110) begin
      p_diff_inverse_r7: assert ((result_o + b_i) == a_i);
    end
    if (fn_i == 3'b111) begin
      p_less_width_r8: assert ($countones(result_o) <= 1 && result_o[0] == result_o[0 +: 1]);
      p_less_sign_r8: assert (((a_i[WIDTH-1] & ~b_i[WIDTH-1]) == 1'b0) || result_o[0]);
      p_less_equal_r8: assert ((a_i != b_i) || (result_o == '0));
    end
    p_zero_flag_r9: assert (zero_o == ($countones(result_o) == 0));
  end

endmodule

bind eightfn_alu eightfn_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .fn_i     (fn_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/eightfn_alu_tb.sv
module eightfn_alu_tb;

  localparam int unsigned W = 32;
  localparam logic [W-1:0] SMIN = 32'h8000_0000;
  localparam logic [W-1:0] SMAX = 32'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [2:0]   fn;
  logic         zf;
  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  eightfn_alu #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .fn_i(fn), .result_o(res), .zero_o(zf)
  );

  // Reference built straight from the requirements.
  function automatic logic [W-1:0] expect_of(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] f);
    case (f)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return x + y;
      3'b100: return x & ~y;
      3'b101: return x | ~y;
      3'b110: return x - y;
      3'b111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply away from the edge, let it settle, check result and zero flag.
  task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] y, logic [2:0] f);
    logic [W-1:0] e;
    @(negedge clk);
    a = x; b = y; fn = f;
    #1;
    e = expect_of(x, y, f);
    check(req, res, e);
    check({req, "/R9 zero"}, {31'd0, zf}, {31'd0, (e == '0)});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset-state result", res, '0);
    check("R9 reset-state zero", {31'd0, zf}, 32'd1);
  endtask

  task automatic t_logic;
    apply("R1 and", 32'hF0F0_1234, 32'hFF00_FF0F, 3'b000);
    apply("R1 and disjoint", 32'hAAAA_AAAA, 32'h5555_5555, 3'b000);
    apply("R2 or", 32'h0F00_0001, 32'h00F0_8000, 3'b001);
    apply("R5 and-not", 32'hFFFF_0000, 32'h0F0F_0F0F, 3'b100);
    apply("R5 and-not self", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b100);
    apply("R6 or-not", 32'h0000_00FF, 32'hFFFF_0000, 3'b101);
    apply("R6 or-not zero b", 32'h1234_5678, 32'h0, 3'b101);
  endtask

  task automatic t_arith;
    apply("R3 add", 32'd1000, 32'd2345, 3'b010);
    apply("R3 add wrap", 32'hFFFF_FFFF, 32'd1, 3'b010);
    apply("R3 add signed ovf", SMAX, 32'd1, 3'b010);
    apply("R7 sub", 32'd5000, 32'd1234, 3'b110);
    apply("R7 sub borrow", 32'd3, 32'd5, 3'b110);
    apply("R7 sub equal", 32'h1357_9BDF, 32'h1357_9BDF, 3'b110);
    apply("R7 sub min", SMIN, 32'd1, 3'b110);
  endtask

  task automatic t_reserved;
    apply("R4 reserved", 32'hFFFF_FFFF, 32'h1234_5678, 3'b011);
    apply("R4 reserved neg", SMIN, SMAX, 3'b011);
  endtask

  task automatic t_less;
    apply("R8 neg<pos", 32'hFFFF_FFFF, 32'd1, 3'b111);
    apply("R8 pos<neg", 32'd1, 32'hFFFF_FFFF, 3'b111);
    apply("R8 min<max ovf", SMIN, SMAX, 3'b111);
    apply("R8 max<min ovf", SMAX, SMIN, 3'b111);
    apply("R8 min<1 ovf", SMIN, 32'd1, 3'b111);
    apply("R8 1<min ovf", 32'd1, SMIN, 3'b111);
    apply("R8 equal", 32'd77, 32'd77, 3'b111);
    apply("R8 small", 32'd4, 32'd9, 3'b111);
  endtask

  task automatic t_history;
    logic [W-1:0] first;
    apply("R10 first", 32'hCAFE_0001, 32'h0000_0F0F, 3'b110);
    first = res;
    apply("R10 other", 32'h1, 32'h2, 3'b001);
    apply("R10 repeat", 32'hCAFE_0001, 32'h0000_0F0F, 3'b110);
    check("R10 same result", res, first);
    @(negedge clk);
    a = 32'd6; b = 32'd6; fn = 3'b110;
    #0.5;
    check("R10 no clock wait", {31'd0, zf}, 32'd1);
  endtask

  initial begin
    a = '0; b = '0; fn = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_logic();
    t_arith();
    t_reserved();
    t_less();
    t_history();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule